// File: doc/BRIEF.md
# Endpoint Test Command Engine

This block sits behind a host-visible register window and lets the host exercise an endpoint's data path. The host sets up a source address, a destination address, a transfer size and interrupt settings. It then writes a one-hot command word. The engine carries out one of three memory jobs over a word-wide request/acknowledge master port. A read job fetches a host buffer and compares its XOR checksum with a programmed value. A write job fills a host buffer with pseudo-random words and stores their checksum. A copy job moves a buffer from one host address to another.

The outcome of each job lands in a status word as one-hot success and failure flags, plus flags for a rejected source or destination address. Every finished job sends a one-cycle request to an external interrupt dispatcher, using the configured interrupt type and number. Three further command bits ask the dispatcher for an interrupt directly, with no memory traffic. A scratch register lets the host confirm basic register access.

Top module: `ep_test_engine`

## Requirements
- R1: The scratch word at byte offset 0x00 returns any written 32-bit value unchanged.
- R2: After reset every register (0x00 scratch, 0x04 command, 0x08 status, 0x0C source, 0x10 destination, 0x14 size in bytes, 0x18 checksum, 0x1C interrupt type, 0x20 interrupt number) reads zero, and no memory or interrupt request is active.
- R3: Command bit 3 reads size/4 words upward from the source address. Status bit 0 is set when the XOR of those words equals the checksum register, and status bit 1 is set otherwise.
- R4: Command bit 4 writes size/4 words upward from the destination address. The data comes from a 32-bit right-shifting Galois LFSR with feedback mask 0x80200003, seeded with 0xACE1; the first word is the seed and the LFSR advances once per word. The XOR of the words is stored in the checksum register and status bit 2 is set (bit 3 on failure).
- R5: Command bit 5 copies size/4 words from the source buffer to the destination buffer, one read followed by one write per word, and sets status bit 4 (bit 5 on failure). When several job bits are set, bit 3 takes precedence over bit 4, and bit 4 over bit 5.
- R6: An address that is zero or not 4-byte aligned is invalid. A job that uses an invalid source sets status bit 7, and one that uses an invalid destination sets status bit 8. Such a job also sets its own fail bit and makes no memory request.
- R7: Any memory acknowledge that carries an error makes the job end with its fail bit set.
- R8: A command with only bits 0, 1 or 2 set sends one interrupt request of type 0, 1 or 2 respectively, carrying the interrupt number register. The lowest set bit wins, no memory request is made, and the status stays zero.
- R9: Each finished memory job, aborted ones included, sends exactly one single-cycle interrupt request carrying the interrupt type and number registers.
- R10: A command write is ignored while a job is pending or running. An accepted command write clears the status register.
- R11: A memory request stays asserted, with address, direction and write data unchanged, until it is acknowledged.
- R12: Register read data appears on the cycle after the read strobe. The command register clears itself the cycle after it is written, when the job is taken up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 for a write, 0 for a read |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after the strobe |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for a memory write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Read data, valid with the acknowledge |
| mem_err | input | 1 | Error flag, valid with the acknowledge |
| irq_req | output | 1 | Single-cycle request to the interrupt dispatcher |
| irq_type | output | 2 | Interrupt type: 0 legacy, 1 MSI, 2 MSI-X |
| irq_num | output | 32 | Interrupt number |

## Verification
Register read data is due one clock after the read strobe. The bench drives the strobe on a falling edge and samples on the next falling edge. A command is taken up one clock after its write, and a finished job's status is final in the same cycle as its interrupt pulse. The bench therefore counts interrupt pulses at rising edges and reads the status only after the expected pulse has arrived. The memory model acknowledges one cycle after it sees a request and returns data with that acknowledge. Buffer contents are compared only after the job's interrupt.

// File: rtl/ep_test_engine.sv
module ep_test_engine #(
  parameter logic [31:0] LFSR_SEED = 32'h0000_ACE1,
  parameter logic [31:0] LFSR_POLY = 32'h8020_0003
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_en,
  input  logic        reg_we,
  input  logic [5:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  input  logic        mem_err,
  output logic        irq_req,
  output logic [1:0]  irq_type,
  output logic [31:0] irq_num
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_FIN} state_t;
  localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_CP = 2'd2;

  state_t      state;
  logic [31:0] magic, src, dst, size, csum, inum, acc, lfsr, hold;
  logic [5:0]  cmd_q;
  logic [8:0]  status;
  logic [1:0]  itype, op;
  logic [29:0] idx;
  logic        err, abort;

  wire        busy     = (state != S_IDLE) || (cmd_q != 6'd0);
  wire [29:0] nwords   = size[31:2];
  wire        last     = idx == nwords - 30'd1;
  wire        src_bad  = (src == 32'd0) || (src[1:0] != 2'b00);
  wire        dst_bad  = (dst == 32'd0) || (dst[1:0] != 2'b00);
  wire        need_src = cmd_q[3] || (!cmd_q[4] && cmd_q[5]);
  wire        need_dst = !cmd_q[3] && (cmd_q[4] || cmd_q[5]);
  wire        bad_s    = need_src && src_bad;
  wire        bad_d    = need_dst && dst_bad;
  wire [1:0]  new_op   = cmd_q[3] ? OP_RD : (cmd_q[4] ? OP_WR : OP_CP);
  wire [31:0] lfsr_nx  = {1'b0, lfsr[31:1]} ^ (lfsr[0] ? LFSR_POLY : 32'd0);
  wire        fail     = abort || err || (op == OP_RD && acc != csum);

  assign mem_req   = (state == S_RD) || (state == S_WR);
  assign mem_we    = state == S_WR;
  assign mem_addr  = ((state == S_WR) ? dst : src) + {idx, 2'b00};
  assign mem_wdata = (op == OP_CP) ? hold : lfsr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; magic <= '0; src <= '0; dst <= '0; size <= '0;
      csum <= '0; inum <= '0; acc <= '0; lfsr <= '0; hold <= '0;
      cmd_q <= '0; status <= '0; itype <= '0; op <= '0; idx <= '0;
      err <= 1'b0; abort <= 1'b0; reg_rdata <= '0;
      irq_req <= 1'b0; irq_type <= '0; irq_num <= '0;
    end else begin
      irq_req <= 1'b0;
      if (reg_en && reg_we) begin
        case (reg_addr[5:2])
          4'd0: magic <= reg_wdata;
          4'd1: if (!busy) begin cmd_q <= reg_wdata[5:0]; status <= '0; end
          4'd3: src   <= reg_wdata;
          4'd4: dst   <= reg_wdata;
          4'd5: size  <= reg_wdata;
          4'd6: csum  <= reg_wdata;
          4'd7: itype <= reg_wdata[1:0];
          4'd8: inum  <= reg_wdata;
          default: ;
        endcase
      end
      if (reg_en && !reg_we) begin
        case (reg_addr[5:2])
          4'd0: reg_rdata <= magic;
          4'd1: reg_rdata <= {26'd0, cmd_q};
          4'd2: reg_rdata <= {23'd0, status};
          4'd3: reg_rdata <= src;
          4'd4: reg_rdata <= dst;
          4'd5: reg_rdata <= size;
          4'd6: reg_rdata <= csum;
          4'd7: reg_rdata <= {30'd0, itype};
          4'd8: reg_rdata <= inum;
          default: reg_rdata <= '0;
        endcase
      end
      case (state)
        S_IDLE: if (cmd_q != 6'd0) begin
          cmd_q <= '0;
          if (cmd_q[5:3] != 3'd0) begin
            op <= new_op; idx <= '0; acc <= '0; lfsr <= LFSR_SEED; err <= 1'b0;
            abort <= bad_s || bad_d;
            if (bad_s || bad_d) begin
              status <= {bad_d, bad_s, 7'd0};
              state  <= S_FIN;
            end else if (nwords == 30'd0) state <= S_FIN;
            else state <= (new_op == OP_WR) ? S_WR : S_RD;
          end else begin
            irq_req  <= 1'b1;
            irq_type <= cmd_q[0] ? 2'd0 : (cmd_q[1] ? 2'd1 : 2'd2);
            irq_num  <= inum;
          end
        end
        S_RD: if (mem_ack) begin
          acc <= acc ^ mem_rdata;
          err <= err | mem_err;
          if (op == OP_CP) begin hold <= mem_rdata; state <= S_WR; end
          else if (last) state <= S_FIN;
          else idx <= idx + 30'd1;
        end
        S_WR: if (mem_ack) begin
          err <= err | mem_err;
          if (op == OP_WR) begin acc <= acc ^ lfsr; lfsr <= lfsr_nx; end
          if (last) state <= S_FIN;
          else begin
            idx   <= idx + 30'd1;
            state <= (op == OP_CP) ? S_RD : S_WR;
          end
        end
        S_FIN: begin
          status   <= status | (9'd1 << {op, fail});
          if (op == OP_WR && !abort) csum <= acc;
          irq_req  <= 1'b1;
          irq_type <= itype;
          irq_num  <= inum;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module ep_test_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_ack,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        irq_req,
  input logic [8:0]  status
);
  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req);
  // R11
  req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  // R6
  addr_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00 && mem_addr != 32'd0);
  // R9
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> !irq_req);
  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> !mem_req);
  // R3
  result_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(status[5:0]) <= 1);
endmodule

bind ep_test_engine ep_test_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .irq_req(irq_req), .status(status)
);

// File: tb/test_ep_test_engine.sv
module test_ep_test_engine;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_en = 1'b0, reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_req, mem_we, irq_req;
  logic [31:0] mem_addr, mem_wdata, irq_num;
  logic [1:0]  irq_type;
  logic        mem_ack = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_rdata = '0;

  ep_test_engine i_ep_test_engine (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0, irq_cnt = 0, acc_cnt = 0, viol = 0;
  logic [1:0]  last_t;
  logic [31:0] last_n;
  logic [31:0] err_at = 32'hFFFF_FFFF;
  logic [31:0] mem [0:255];
  logic        p_req = 1'b0, p_ack = 1'b0;
  logic [31:0] p_addr = '0;

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      acc_cnt++;
      mem_err <= (mem_addr == err_at);
      mem_rdata <= mem[mem_addr[9:2]];
      if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
    end
  end

  always @(posedge clk) begin
    if (rst_n && irq_req) begin irq_cnt++; last_t = irq_type; last_n = irq_num; end
    if (rst_n && p_req && !p_ack && (!mem_req || mem_addr != p_addr)) viol++;
    p_req = mem_req; p_ack = mem_ack; p_addr = mem_addr;
  end

  function automatic logic [31:0] lfsr_step(input logic [31:0] s);
    return {1'b0, s[31:1]} ^ (s[0] ? 32'h8020_0003 : 32'd0);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_en = 0; reg_we = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); reg_en = 1; reg_we = 0; reg_addr = a;
    @(negedge clk); reg_en = 0; d = reg_rdata;
  endtask

  task automatic run_job(input logic [5:0] cmd, output logic [31:0] st);
    int start = irq_cnt;
    wr(6'h04, {26'd0, cmd});
    for (int i = 0; i < 3000 && irq_cnt == start; i++) @(negedge clk);
    rd(6'h08, st);
  endtask

  task automatic fill(input logic [31:0] a, input int n, output logic [31:0] x);
    x = 0;
    for (int i = 0; i < n; i++) begin
      mem[a[9:2] + i[7:0]] = $urandom;
      x ^= mem[a[9:2] + i[7:0]];
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, x, st, s;
    int n, bad, c0, k;
    void'($urandom(1234));
    for (int i = 0; i < 256; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R2 reset state
    for (int r = 0; r < 9; r++) begin
      rd(6'(r * 4), d);
      check("R2 reset reg", d, 0);
    end
    check("R2 idle outputs", {31'd0, mem_req | irq_req}, 0);
    // R1 scratch
    for (int i = 0; i < 4; i++) begin
      x = (i == 0) ? 32'hFFFF_FFFF : $urandom;
      wr(6'h00, x); rd(6'h00, d);
      check("R1 scratch", d, x);
    end
    // R3 read jobs, random
    for (int i = 0; i < 6; i++) begin
      n = 1 + $urandom % 16;
      s = 32'h40 + 4 * ($urandom % 32);
      fill(s, n, x);
      wr(6'h0C, s); wr(6'h14, n * 4);
      wr(6'h18, (i % 2 == 1) ? x ^ 32'h1 : x);
      run_job(6'h08, st);
      check("R3 read status", st, (i % 2 == 1) ? 32'h2 : 32'h1);
      // R12 command self-clears
      rd(6'h04, d);
      check("R12 cmd cleared", d, 0);
    end
    // R4 write jobs
    for (int i = 0; i < 4; i++) begin
      n = 1 + $urandom % 20;
      s = 32'h200 + 4 * ($urandom % 32);
      wr(6'h10, s); wr(6'h14, n * 4);
      run_job(6'h10, st);
      check("R4 write status", st, 32'h4);
      x = 32'h0000_ACE1; d = 0; bad = 0;
      for (int j = 0; j < n; j++) begin
        if (mem[s[9:2] + j[7:0]] !== x) bad++;
        d ^= x; x = lfsr_step(x);
      end
      check("R4 write data", bad, 0);
      rd(6'h18, st);
      check("R4 write checksum", st, d);
    end
    // R5 copy jobs, bit 3 precedence when combined
    for (int i = 0; i < 4; i++) begin
      n = 1 + $urandom % 16;
      s = 32'h40 + 4 * ($urandom % 32);
      fill(s, n, x);
      wr(6'h0C, s); wr(6'h10, 32'h300); wr(6'h14, n * 4);
      run_job(6'h20, st);
      check("R5 copy status", st, 32'h10);
      bad = 0;
      for (int j = 0; j < n; j++) if (mem[8'hC0 + j[7:0]] !== mem[s[9:2] + j[7:0]]) bad++;
      check("R5 copy data", bad, 0);
    end
    wr(6'h18, x);
    run_job(6'h38, st);
    check("R5 priority read first", st, 32'h1);
    // R6 invalid addresses
    c0 = acc_cnt;
    wr(6'h0C, 32'h0);   run_job(6'h08, st); check("R6 zero src", st, 32'h82);
    wr(6'h0C, 32'h102); run_job(6'h08, st); check("R6 unaligned src", st, 32'h82);
    wr(6'h10, 32'h11);  run_job(6'h10, st); check("R6 unaligned dst", st, 32'h108);
    wr(6'h0C, 32'h0); wr(6'h10, 32'h3); run_job(6'h20, st);
    check("R6 copy both bad", st, 32'h1A0);
    check("R6 no memory access", acc_cnt - c0, 0);
    // R9 completion interrupt with configured type/number
    wr(6'h1C, 32'h1); wr(6'h20, 32'd7);
    c0 = irq_cnt;
    wr(6'h0C, 32'h80); wr(6'h14, 32'd8); fill(32'h80, 2, x); wr(6'h18, x);
    run_job(6'h08, st);
    check("R9 irq type", {30'd0, last_t}, 1);
    check("R9 irq number", last_n, 7);
    repeat (20) @(negedge clk);
    check("R9 single irq", irq_cnt - c0, 1);
    // R7 error responses
    err_at = 32'h84;
    run_job(6'h08, st); check("R7 read error", st, 32'h2);
    wr(6'h10, 32'h300); run_job(6'h20, st); check("R7 copy error", st, 32'h20);
    err_at = 32'hFFFF_FFFF;
    // R8 direct interrupt commands
    wr(6'h20, 32'd5);
    for (int b = 0; b < 3; b++) begin
      c0 = acc_cnt;
      run_job(6'(1 << b), st);
      check("R8 irq type", {30'd0, last_t}, b);
      check("R8 irq number", last_n, 5);
      check("R8 status and memory quiet", st | (acc_cnt - c0), 0);
    end
    run_job(6'h06, st);
    check("R8 lowest bit wins", {30'd0, last_t}, 1);
    // R10 busy ignore
    fill(32'h40, 40, x);
    wr(6'h0C, 32'h40); wr(6'h10, 32'h300); wr(6'h14, 32'd160);
    c0 = irq_cnt;
    wr(6'h04, 32'h20);
    repeat (5) @(negedge clk);
    wr(6'h04, 32'h08);
    rd(6'h04, d); check("R10 busy cmd ignored", d, 0);
    rd(6'h08, d); check("R10 status cleared", d, 0);
    k = 0;
    while (irq_cnt == c0 && k < 3000) begin @(negedge clk); k++; end
    rd(6'h08, st); check("R10 copy only result", st, 32'h10);
    repeat (50) @(negedge clk);
    check("R10 no extra job", irq_cnt - c0, 1);
    // R11 request hold
    check("R11 request held", viol, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule